// File: doc/BRIEF.md
# Multi-Timer Event Timer Register Front End

This block is the memory-mapped register front end for a group of event timers that all count from one shared 32-bit free-running main counter. It sits in a 1024-byte window and accepts 4-byte and 8-byte read and write requests on a plain address/data/strobe bus. Every register is 64 bits wide. A 4-byte access reaches either the low or the high half of a register, selected by bit 2 of its offset.

The block holds the registers that all timers share: a read-only capability word, the global configuration (counter run and legacy interrupt routing), the interrupt status bits and the main counter. From these it produces the run and legacy-route controls and single-cycle start, stop and reschedule pulses. Accesses to the per-timer register slots are not stored here. They are decoded and passed to the timer channels with their data and byte mask already shifted to the correct lane, and the read data the channels return is shaped the same way.

The main counter advances once for each cycle in which the tick-enable input is high, but only while the run bit is set. Each read of the counter also copies the value read into a last-read register, which the timer channels use.

Top module: `evt_timer_regfront`

## Requirements
- R1: Only addresses in [BASE_ADDR, BASE_ADDR+1024), with BASE_ADDR defaulting to 0xFED00000, are claimed. A request outside this range produces no response pulse and changes no state.
- R2: Size codes are req_size 2 = 4 bytes and 3 = 8 bytes. Sizes 0 and 1, and any access not aligned to its own width, are illegal. An illegal write is dropped. An illegal read still pulses rsp_valid and returns zero.
- R3: A 4-byte write whose offset has bit 2 set lands in bits 63:32 of the 64-bit register, with its data and byte mask shifted up by 32. A 4-byte read with bit 2 set returns bits 63:32 in rsp_rdata[31:0]. Every 4-byte read returns zero in bits 63:32.
- R4: The capability word is at offset 0x000. Its low 32 bits read 0x80868701 with the defaults: revision 1 in bits 7:0, timer count minus one in bits 12:8, bit 13 = 0 (32-bit counter), bit 15 = 1 (legacy routing available), vendor 0x8086 in bits 31:16.
- R5: The high 32 bits of the capability word hold the tick period in femtoseconds, 100000000 (0x05F5E100) at 10 MHz.
- R6: The configuration register is at offset 0x010. Bit 0 is run and bit 1 is legacy route. Both can be written under the byte mask and read back. All other bits read as zero. Their current values appear on cnt_enable and legacy_route.
- R7: start_pulse is high for one cycle, in the cycle after a configuration write that changes run from 0 to 1. stop_pulse behaves the same way for a change from 1 to 0. A write that leaves run unchanged produces no pulse.
- R8: Interrupt status is at offset 0x020, one bit per timer in the low bits. Writing 1 clears a bit that is set. Writing 0 has no effect. A high isr_set bit sets its status bit, and a set in the same cycle as a clear wins.
- R9: The 32-bit main counter increments by one on each clock with tick_en high while run is set, and wraps from 0xFFFFFFFF to 0. It holds while run is clear.
- R10: The counter is at offset 0x0F0. A write updates the masked bits of the counter zero-extended to 64 bits, so a write to the upper lane leaves the counter unchanged. A write wins over a tick in the same cycle. If run is set, resched_pulse is high for one cycle afterwards.
- R11: A legal counter read returns the counter value as it stood in the request cycle, and last_read takes that same value.
- R12: Reads of offsets that decode to no register return zero. Writes to such offsets change nothing.
- R13: Timer n owns offsets 0x100+0x20*n, with its configuration at +0x00, comparator at +0x08 and route at +0x10 (tmr_reg 0, 1, 2). In the request cycle a legal access there drives tmr_wr or tmr_rd, tmr_sel = n, tmr_reg, and the lane-shaped tmr_wdata/tmr_wmask. The read response is tmr_rdata, shaped per R3. Slot +0x18 is unknown (R12).
- R14: Reset clears configuration, interrupt status, the counter, last_read and all pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | log2 of access bytes (2 = 4 B, 3 = 8 B) |
| req_wdata | input | 64 | Write data, low-aligned for 4-byte writes |
| rsp_valid | output | 1 | Read response strobe, the cycle after a claimed read |
| rsp_rdata | output | 64 | Read response data |
| tick_en | input | 1 | Counter tick enable |
| isr_set | input | NUM_TIMERS | Interrupt status set requests from the channels |
| cnt_enable | output | 1 | Global run bit |
| legacy_route | output | 1 | Legacy routing bit |
| start_pulse | output | 1 | Run changed 0 to 1 |
| stop_pulse | output | 1 | Run changed 1 to 0 |
| resched_pulse | output | 1 | Counter written while running |
| main_count | output | 32 | Main counter value |
| last_read | output | 32 | Counter value at the last counter read |
| isr_status | output | NUM_TIMERS | Interrupt status bits |
| tmr_wr | output | 1 | Write to a timer slot |
| tmr_rd | output | 1 | Read of a timer slot |
| tmr_sel | output | $clog2(NUM_TIMERS) | Timer index |
| tmr_reg | output | 2 | Slot: 0 config, 1 comparator, 2 route |
| tmr_wdata | output | 64 | Lane-shaped write data |
| tmr_wmask | output | 64 | Lane-shaped write bit mask |
| tmr_rdata | input | 64 | Read data from the selected timer slot |

## Verification
A behavioural model in the bench tracks the run and route bits, the pulses, the interrupt status, the counter and last_read, and all of them are compared against the design on every clock. Counter ticks come from three sources: a pseudo-random pattern, which checks that the count follows run and tick_en exactly; tick_en held high, which checks that a write wins over a tick and that the counter wraps; and no ticks, which checks that the counter holds. Each register is accessed with full 8-byte accesses and with low- and high-lane 4-byte accesses, so a shift error in either direction shows up. Misaligned accesses, illegal sizes and out-of-window addresses are each issued against a register whose value would visibly change if the access leaked through. Status clears are tried with a clear that covers set bits, a clear that covers clear bits, a clear on the upper lane and a clear that collides with a set.

// File: rtl/etr_pkg.sv
package etr_pkg;

    localparam int REG_W = 64;
    localparam int HALF_W = 32;

    // access size codes (log2 of bytes)
    localparam logic [1:0] SZ_4B = 2'd2;
    localparam logic [1:0] SZ_8B = 2'd3;

    // word offsets inside the window
    localparam logic [11:0] OFS_CAP  = 12'h000;
    localparam logic [11:0] OFS_CFG  = 12'h010;
    localparam logic [11:0] OFS_ISR  = 12'h020;
    localparam logic [11:0] OFS_CNT  = 12'h0F0;
    localparam logic [11:0] OFS_TMR  = 12'h100;
    localparam int          TMR_SPAN = 32;

    typedef enum logic [1:0] {
        TREG_CFG   = 2'd0,
        TREG_CMP   = 2'd1,
        TREG_ROUTE = 2'd2,
        TREG_NONE  = 2'd3
    } treg_e;

    typedef enum logic [2:0] {
        RS_CAP, RS_CFG, RS_ISR, RS_CNT, RS_TMR, RS_NONE
    } rsel_e;

    typedef struct packed {
        logic             legal;
        logic [REG_W-1:0] wdata;
        logic [REG_W-1:0] wmask;
    } lane_t;

    function automatic logic [REG_W-1:0] lane_read(
        input logic [REG_W-1:0] d,
        input logic             wide,
        input logic             upper
    );
        if (wide)       return d;
        else if (upper) return {{HALF_W{1'b0}}, d[REG_W-1:HALF_W]};
        else            return {{HALF_W{1'b0}}, d[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/etr_lane_shaper.sv
module etr_lane_shaper
    import etr_pkg::*;
(
    input  logic [2:0]       addr_lo,
    input  logic [1:0]       size,
    input  logic [REG_W-1:0] wdata_in,
    output lane_t            lane
);
    logic wide, narrow;

    always_comb begin
        wide   = (size == SZ_8B) && (addr_lo == 3'b000);
        narrow = (size == SZ_4B) && (addr_lo[1:0] == 2'b00);
        lane.legal = wide || narrow;
        if (size == SZ_8B) begin
            lane.wdata = wdata_in;
            lane.wmask = '1;
        end else if (addr_lo[2]) begin
            lane.wdata = {wdata_in[HALF_W-1:0], {HALF_W{1'b0}}};
            lane.wmask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
        end else begin
            lane.wdata = {{HALF_W{1'b0}}, wdata_in[HALF_W-1:0]};
            lane.wmask = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        end
    end
endmodule

// File: rtl/etr_main_counter.sv
module etr_main_counter
    import etr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] wmask,
    output logic [CNT_W-1:0] count
);
    logic [REG_W-1:0] merged;

    always_comb begin
        merged = ({{(REG_W-CNT_W){1'b0}}, count} & ~wmask) | (wdata & wmask);
    end

    always_ff @(posedge clk) begin
        if (rst)               count <= '0;
        else if (wr)           count <= merged[CNT_W-1:0];
        else if (run && tick)  count <= count + 1'b1;
    end

    // R9: no tick or no run and no write keeps the counter still
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (!wr && !(run && tick)) |=> $stable(count));
    // R9: one tick while running advances by exactly one
    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        (!wr && run && tick) |=> (count == $past(count) + 1'b1));
endmodule

// File: rtl/etr_global_regs.sv
module etr_global_regs
    import etr_pkg::*;
#(
    parameter int NUM_TIMERS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_wr,
    input  logic                  isr_wr,
    input  logic [REG_W-1:0]      wdata,
    input  logic [REG_W-1:0]      wmask,
    input  logic [NUM_TIMERS-1:0] isr_set,
    output logic                  run,
    output logic                  legacy,
    output logic                  start_pulse,
    output logic                  stop_pulse,
    output logic [NUM_TIMERS-1:0] isr
);
    logic [1:0]            cfg_next;
    logic [NUM_TIMERS-1:0] clr_bits;

    always_comb begin
        cfg_next = ({legacy, run} & ~wmask[1:0]) | (wdata[1:0] & wmask[1:0]);
        clr_bits = isr_wr ? (wdata[NUM_TIMERS-1:0] & wmask[NUM_TIMERS-1:0] & isr) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run         <= 1'b0;
            legacy      <= 1'b0;
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            isr         <= '0;
        end else begin
            start_pulse <= cfg_wr && !run && cfg_next[0];
            stop_pulse  <= cfg_wr && run && !cfg_next[0];
            if (cfg_wr) begin
                run    <= cfg_next[0];
                legacy <= cfg_next[1];
            end
            isr <= (isr & ~clr_bits) | isr_set;
        end
    end

    // R7: start and stop never coincide
    a_r7_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && stop_pulse));
    // R7: a start pulse follows a rising run bit
    a_r7_start_edge: assert property (@(posedge clk) disable iff (rst)
        start_pulse |-> (run && !$past(run)));
    // R8: a requested set always lands
    a_r8_set_lands: assert property (@(posedge clk) disable iff (rst)
        (|isr_set) |=> ((isr & $past(isr_set)) == $past(isr_set)));
    // R8: a cleared bit without a set is gone
    a_r8_clear_lands: assert property (@(posedge clk) disable iff (rst)
        isr_wr |=> ((isr & $past(clr_bits & ~isr_set)) == '0));
endmodule

// File: rtl/evt_timer_regfront.sv
module evt_timer_regfront
    import etr_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR  = 32'hFED0_0000,
    parameter int          WIN_BYTES  = 1024,
    parameter int          NUM_TIMERS = 8,
    parameter int          TICK_HZ    = 10_000_000,
    parameter logic [15:0] VENDOR_ID  = 16'h8086,
    parameter logic [7:0]  REVISION   = 8'h01
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    input  logic                          req_write,
    input  logic [31:0]                   req_addr,
    input  logic [1:0]                    req_size,
    input  logic [63:0]                   req_wdata,
    output logic                          rsp_valid,
    output logic [63:0]                   rsp_rdata,
    input  logic                          tick_en,
    input  logic [NUM_TIMERS-1:0]         isr_set,
    output logic                          cnt_enable,
    output logic                          legacy_route,
    output logic                          start_pulse,
    output logic                          stop_pulse,
    output logic                          resched_pulse,
    output logic [31:0]                   main_count,
    output logic [31:0]                   last_read,
    output logic [NUM_TIMERS-1:0]         isr_status,
    output logic                          tmr_wr,
    output logic                          tmr_rd,
    output logic [$clog2(NUM_TIMERS)-1:0] tmr_sel,
    output logic [1:0]                    tmr_reg,
    output logic [63:0]                   tmr_wdata,
    output logic [63:0]                   tmr_wmask,
    input  logic [63:0]                   tmr_rdata
);
    localparam int OFF_W  = $clog2(WIN_BYTES);
    localparam int TIDX_W = $clog2(NUM_TIMERS);
    localparam int CNT_W  = 32;
    localparam logic [63:0] PERIOD_FS = 64'd1_000_000_000_000_000 / 64'(TICK_HZ);
    localparam logic [63:0] CAP_WORD  = {PERIOD_FS[31:0], VENDOR_ID, 1'b1, 1'b0, 1'b0,
                                         5'(NUM_TIMERS - 1), REVISION};
    localparam int TMR_END = int'(OFS_TMR) + NUM_TIMERS * TMR_SPAN;

    logic [31:0]      win_ofs;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] word;
    logic             in_win, claim, acc_ok;
    lane_t            lane;
    rsel_e            rsel;
    logic [OFF_W-1:0] tofs;
    treg_e            tslot;
    logic [REG_W-1:0] raw;

    always_comb begin
        win_ofs = req_addr - BASE_ADDR;
        in_win  = win_ofs < 32'(WIN_BYTES);
        off     = win_ofs[OFF_W-1:0];
        word    = {off[OFF_W-1:3], 3'b000};
        claim   = req_valid && in_win;
        tofs    = off - OFF_W'(OFS_TMR);
    end

    etr_lane_shaper u_lane (
        .addr_lo  (off[2:0]),
        .size     (req_size),
        .wdata_in (req_wdata),
        .lane     (lane)
    );

    always_comb begin
        acc_ok = claim && lane.legal;
        tslot  = treg_e'(tofs[4:3]);
        if (word == OFF_W'(OFS_CAP))      rsel = RS_CAP;
        else if (word == OFF_W'(OFS_CFG)) rsel = RS_CFG;
        else if (word == OFF_W'(OFS_ISR)) rsel = RS_ISR;
        else if (word == OFF_W'(OFS_CNT)) rsel = RS_CNT;
        else if (int'(off) >= int'(OFS_TMR) && int'(off) < TMR_END && tslot != TREG_NONE)
                                          rsel = RS_TMR;
        else                              rsel = RS_NONE;
    end

    // per-timer forwarding
    always_comb begin
        tmr_wr    = acc_ok && req_write && (rsel == RS_TMR);
        tmr_rd    = acc_ok && !req_write && (rsel == RS_TMR);
        tmr_sel   = tofs[5 +: TIDX_W];
        tmr_reg   = tslot;
        tmr_wdata = lane.wdata;
        tmr_wmask = lane.wmask;
    end

    logic cfg_wr, isr_wr, cnt_wr;
    assign cfg_wr = acc_ok && req_write && (rsel == RS_CFG);
    assign isr_wr = acc_ok && req_write && (rsel == RS_ISR);
    assign cnt_wr = acc_ok && req_write && (rsel == RS_CNT);

    etr_global_regs #(.NUM_TIMERS(NUM_TIMERS)) u_glob (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .isr_wr      (isr_wr),
        .wdata       (lane.wdata),
        .wmask       (lane.wmask),
        .isr_set     (isr_set),
        .run         (cnt_enable),
        .legacy      (legacy_route),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .isr         (isr_status)
    );

    etr_main_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .run   (cnt_enable),
        .tick  (tick_en),
        .wr    (cnt_wr),
        .wdata (lane.wdata),
        .wmask (lane.wmask),
        .count (main_count)
    );

    always_comb begin
        unique case (rsel)
            RS_CAP:  raw = CAP_WORD;
            RS_CFG:  raw = {62'd0, legacy_route, cnt_enable};
            RS_ISR:  raw = {{(REG_W-NUM_TIMERS){1'b0}}, isr_status};
            RS_CNT:  raw = {{(REG_W-CNT_W){1'b0}}, main_count};
            RS_TMR:  raw = tmr_rdata;
            default: raw = '0;
        endcase
    end

    logic rd_claim;
    assign rd_claim = claim && !req_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid     <= 1'b0;
            rsp_rdata     <= '0;
            last_read     <= '0;
            resched_pulse <= 1'b0;
        end else begin
            rsp_valid     <= rd_claim;
            rsp_rdata     <= (rd_claim && lane.legal)
                             ? lane_read(raw, req_size == SZ_8B, off[2]) : '0;
            resched_pulse <= cnt_wr && cnt_enable;
            if (rd_claim && lane.legal && rsel == RS_CNT)
                last_read <= main_count;
        end
    end

    // R2: an illegal read answers with zero
    a_r2_bad_read_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rd_claim && !lane.legal) |-> (rsp_valid && rsp_rdata == '0));
    // R1: unclaimed addresses produce no response
    a_r1_no_claim: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !in_win) |=> !rsp_valid);
    // R13: forwarding strobes are exclusive
    a_r13_fwd_excl: assert property (@(posedge clk) disable iff (rst)
        !(tmr_wr && tmr_rd));
endmodule

// File: tb/tb_evt_timer_regfront.sv
module tb_evt_timer_regfront;
    localparam logic [31:0] BASE = 32'hFED0_0000;
    localparam int NT = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = 2'd2;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic        tick_en = 1'b0;
    logic [NT-1:0] isr_set = '0;
    logic        cnt_enable, legacy_route, start_pulse, stop_pulse, resched_pulse;
    logic [31:0] main_count, last_read;
    logic [NT-1:0] isr_status;
    logic        tmr_wr, tmr_rd;
    logic [2:0]  tmr_sel;
    logic [1:0]  tmr_reg;
    logic [63:0] tmr_wdata, tmr_wmask, tmr_rdata;

    assign tmr_rdata = {16'hC0DE, 5'd0, tmr_sel, 6'd0, tmr_reg, 32'h600D_F00D};

    always #4 clk = ~clk;

    evt_timer_regfront dut (.*);

    int tests = 0, fails = 0;
    int tick_mode = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit cmp_on = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // tick source
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick_en <= (tick_mode == 2) ? 1'b1 : (tick_mode == 1) ? lfsr[0] : 1'b0;
    end

    // behavioural reference
    logic        m_run = 0, m_leg = 0, m_start = 0, m_stop = 0, m_resch = 0;
    logic [31:0] m_cnt = 0, m_last = 0;
    logic [NT-1:0] m_isr = 0;
    logic [31:0] t_ofs;
    logic [63:0] t_wd, t_m, t_c;
    logic [1:0]  t_cfg;
    bit t_legal, t_claim;

    always @(posedge clk) begin
        if (rst) begin
            m_run = 0; m_leg = 0; m_start = 0; m_stop = 0; m_resch = 0;
            m_cnt = 0; m_last = 0; m_isr = 0;
        end else begin
            t_ofs   = req_addr - BASE;
            t_claim = req_valid && (t_ofs < 1024);
            t_legal = (req_size == 3 && t_ofs[2:0] == 0) || (req_size == 2 && t_ofs[1:0] == 0);
            if (req_size == 3) begin t_wd = req_wdata; t_m = '1; end
            else if (t_ofs[2]) begin t_wd = {req_wdata[31:0], 32'd0}; t_m = {32'hFFFF_FFFF, 32'd0}; end
            else begin t_wd = {32'd0, req_wdata[31:0]}; t_m = {32'd0, 32'hFFFF_FFFF}; end
            t_ofs[2:0] = 3'd0;
            m_start = 0; m_stop = 0; m_resch = 0;
            if (t_claim && t_legal && !req_write && t_ofs == 32'hF0) m_last = m_cnt;
            if (t_claim && t_legal && req_write && t_ofs == 32'hF0) begin
                t_c = (({32'd0, m_cnt} & ~t_m) | (t_wd & t_m));
                m_cnt = t_c[31:0];
                m_resch = m_run;
            end else if (m_run && tick_en) m_cnt = m_cnt + 1;
            m_isr = m_isr | isr_set;
            if (t_claim && t_legal && req_write && t_ofs == 32'h20) begin
                t_c = t_wd & t_m;
                m_isr = (m_isr & ~(t_c[NT-1:0] & ~isr_set)) | isr_set;
            end
            if (t_claim && t_legal && req_write && t_ofs == 32'h10) begin
                t_cfg = ({m_leg, m_run} & ~t_m[1:0]) | (t_wd[1:0] & t_m[1:0]);
                m_start = !m_run && t_cfg[0];
                m_stop  = m_run && !t_cfg[0];
                m_run = t_cfg[0]; m_leg = t_cfg[1];
            end
        end
    end

    // per-clock comparison
    always @(negedge clk) if (cmp_on) begin
        chk(cnt_enable == m_run, "R6 run", 64'(cnt_enable), 64'(m_run));
        chk(legacy_route == m_leg, "R6 legacy", 64'(legacy_route), 64'(m_leg));
        chk(start_pulse == m_start, "R7 start", 64'(start_pulse), 64'(m_start));
        chk(stop_pulse == m_stop, "R7 stop", 64'(stop_pulse), 64'(m_stop));
        chk(resched_pulse == m_resch, "R10 resched", 64'(resched_pulse), 64'(m_resch));
        chk(main_count == m_cnt, "R9 count", 64'(main_count), 64'(m_cnt));
        chk(last_read == m_last, "R11 last_read", 64'(last_read), 64'(m_last));
        chk(isr_status == m_isr, "R8 isr", 64'(isr_status), 64'(m_isr));
    end

    // one bus cycle, called just after a negedge; returns at the next negedge
    task automatic bus(input logic wr, input logic [31:0] ofs, input logic [1:0] sz, input logic [63:0] d);
        req_valid = 1; req_write = wr; req_addr = BASE + ofs; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic wr(input logic [31:0] ofs, input logic [1:0] sz, input logic [63:0] d);
        bus(1, ofs, sz, d);
    endtask

    task automatic rd(input logic [31:0] ofs, input logic [1:0] sz, input logic [63:0] exp, input string tag);
        bus(0, ofs, sz, 64'd0);
        chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk(rsp_rdata == exp, tag, rsp_rdata, exp);
    endtask

    task automatic finish_up;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    logic [31:0] snap;

    initial begin
        repeat (3) @(negedge clk);
        cmp_on = 1;                      // R14: reset state compared here
        rst = 0;
        @(negedge clk);
        chk(rsp_valid == 0 && main_count == 0, "R14 reset", 64'(main_count), 64'd0);

        // R4 / R5 / R3 capability word
        rd(32'h000, 2'd2, 64'h0000_0000_8086_8701, "R4 cap low");
        rd(32'h004, 2'd2, 64'h0000_0000_05F5_E100, "R5 cap high");
        rd(32'h000, 2'd3, 64'h05F5_E100_8086_8701, "R3 cap 8B");

        // R2 illegal accesses
        rd(32'h004, 2'd3, 64'd0, "R2 misaligned 8B");
        rd(32'h002, 2'd2, 64'd0, "R2 misaligned 4B");
        rd(32'h000, 2'd1, 64'd0, "R2 size 2B");
        wr(32'h010, 2'd0, 64'h3);        // dropped, compared per clock
        wr(32'h014, 2'd3, 64'h3);        // misaligned 8B, dropped
        rd(32'h010, 2'd3, 64'd0, "R2 cfg untouched");

        // R6 / R7 configuration and pulses
        wr(32'h010, 2'd3, 64'h1);
        @(negedge clk);
        rd(32'h010, 2'd2, 64'h1, "R6 cfg run");
        wr(32'h010, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(32'h010, 2'd3, 64'h3, "R6 cfg only two bits");
        wr(32'h014, 2'd2, 64'hFFFF_FFFF);  // upper lane: no change
        rd(32'h010, 2'd2, 64'h3, "R3 upper lane cfg");
        wr(32'h010, 2'd2, 64'h3);          // unchanged: no pulse

        // R9 random ticks while running
        tick_mode = 1;
        repeat (200) @(negedge clk);
        snap = m_cnt;
        rd(32'h0F0, 2'd2, 64'(snap), "R11 counter read");
        chk(last_read == snap, "R11 last_read capture", 64'(last_read), 64'(snap));
        rd(32'h0F4, 2'd2, 64'd0, "R3 counter upper zero");

        // R10 writes win over ticks, upper lane ignored, wrap
        tick_mode = 2;
        @(negedge clk);
        wr(32'h0F0, 2'd3, 64'hDEAD_BEEF_FFFF_FFF0);
        wr(32'h0F4, 2'd2, 64'h1234_5678);
        repeat (40) @(negedge clk);     // wraps past zero (R9)
        chk(m_cnt < 32'd100, "R9 wrapped", 64'(m_cnt), 64'd0);
        wr(32'h0F0, 2'd2, 64'h0000_0500);

        // hold while stopped
        wr(32'h010, 2'd2, 64'h2);
        repeat (20) @(negedge clk);
        snap = m_cnt;
        rd(32'h0F0, 2'd3, 64'(snap), "R9 held while stopped");
        wr(32'h0F0, 2'd2, 64'h77);      // no resched while stopped
        tick_mode = 1;

        // R8 interrupt status
        isr_set = 8'hA5; @(negedge clk); isr_set = 0;
        rd(32'h020, 2'd2, 64'hA5, "R8 isr set");
        wr(32'h020, 2'd2, 64'h0A);       // only bit 1? 0x0A covers bits 1,3 (clear), clears nothing set
        rd(32'h020, 2'd2, 64'hA5, "R8 clear of zero bits");
        wr(32'h024, 2'd2, 64'hFF);       // upper lane clears nothing
        rd(32'h020, 2'd3, 64'hA5, "R8 upper lane no clear");
        req_valid = 1; req_write = 1; req_addr = BASE + 32'h020; req_size = 2'd3;
        req_wdata = 64'h81; isr_set = 8'h01;
        @(negedge clk);
        req_valid = 0; req_write = 0; isr_set = 0;
        rd(32'h020, 2'd2, 64'h25, "R8 set wins, bit7 cleared");

        // R12 unknown offsets
        rd(32'h030, 2'd3, 64'd0, "R12 unknown read");
        wr(32'h040, 2'd3, 64'hFFFF);
        rd(32'h1F8, 2'd3, 64'd0, "R12 timer slot 3");

        // R13 forwarding
        req_valid = 1; req_write = 1; req_addr = BASE + 32'h1AC; req_size = 2'd2;
        req_wdata = 64'h1122_3344;
        #1;
        chk(tmr_wr && !tmr_rd && tmr_sel == 3'd5 && tmr_reg == 2'd1, "R13 fwd write strobe",
            {58'd0, tmr_wr, tmr_sel, tmr_reg}, {58'd0, 1'b1, 3'd5, 2'd1});
        chk(tmr_wdata == 64'h1122_3344_0000_0000, "R13 fwd wdata", tmr_wdata, 64'h1122_3344_0000_0000);
        chk(tmr_wmask == 64'hFFFF_FFFF_0000_0000, "R13 fwd wmask", tmr_wmask, 64'hFFFF_FFFF_0000_0000);
        @(negedge clk);
        req_valid = 0; req_write = 0;
        rd(32'h1F0, 2'd3, 64'hC0DE_0702_600D_F00D, "R13 fwd read timer7 route");
        rd(32'h104, 2'd2, 64'h0000_0000_C0DE_0000, "R13 fwd read upper lane");

        // R1 out of window
        bus(0, 32'h400, 2'd3, 64'd0);
        chk(rsp_valid == 0, "R1 no response", 64'(rsp_valid), 64'd0);
        wr(32'h410, 2'd3, 64'h1);        // alias of cfg outside window
        rd(32'h010, 2'd3, 64'h2, "R1 no side effect");

        // R14 reset in mid run
        wr(32'h010, 2'd3, 64'h3);
        repeat (10) @(negedge clk);
        rst = 1; @(negedge clk); rst = 0;
        chk(main_count == 0 && isr_status == 0 && !cnt_enable, "R14 mid reset",
            64'(main_count), 64'd0);
        @(negedge clk);
        finish_up();
    end
endmodule